// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor run clause 22 management transactions on a two-wire MDC/MDIO management link. Software programs it through a small word-addressed register bus. A write frame starts when the write-data register is written. A read frame starts on a 0-to-1 transition of the read bit in the command register. Software learns that a frame has finished, and that read data is ready, by polling an indicator register that carries separate busy and not-valid flags.

The block serialises the frame, generates MDC from the system clock through a programmable divider, and drives MDIO through a separate output and output-enable pair. It samples the incoming MDIO line during the data phase of a read. A reset bit in the configuration register abandons any frame in progress and returns the engine to idle.

The register bus is a plain control interface with no handshake. A write takes effect at the clock edge where `bus_we` is high. A read is a combinational view selected by `bus_addr`.

Top module: `mdio_master`

## Requirements
- R1: The address register (offset 2) holds the PHY address in bits [12:8] and the register number in bits [4:0]. Reading it returns exactly those fields, with all other bits zero.
- R2: Writing offset 3 while idle latches bits [15:0] and starts a write frame. On the wire the frame is 32 ones, then 01, then opcode 01, the PHY address, the register number, turnaround 10 and the 16 data bits, most significant bit first, with the output enabled for all 64 bits.
- R3: A read frame starts only when bit 0 of the command register (offset 1) goes from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R4: Bit 0 of the indicator register (offset 5) is the busy flag. It is set from the clock edge that starts a frame until that frame's last MDC falling edge, and it stays set for all 64 MDC rising edges.
- R5: Bit 1 of the indicator register is the not-valid flag. It is set when a read starts and cleared when the read completes. The read data register (offset 4, bits [15:0]) then holds the 16 bits that were sampled.
- R6: A read frame sends opcode 10. The output enable is low for the two turnaround bits and the 16 data bits, which are bit indices 46 to 63 of the frame.
- R7: Within a frame, MDC has a period of 2*(D+1) system clocks, where D is the divider in bits [7:0] of the configuration register (offset 0). MDIO output changes only when MDC falls. Input is sampled when MDC rises.
- R8: A write to offset 3, or a rising edge of the read bit, that arrives while busy is set starts no frame. The running frame is unchanged, and the write-data register keeps its value.
- R9: Writing the configuration register with bit 31 set aborts any frame. The next cycle shows busy and not-valid clear, MDC low and the output disabled, and the divider is left unchanged. A configuration write with bit 31 clear loads the divider.
- R10: Out of reset and after every frame, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input line |

## Verification
The bench sweeps every PHY address with write frames and runs read and write frames at several divider values. It checks each of the 64 sampled bits, the output-enable pattern and the MDC period, so an off-by-one in the divider or a misplaced field shows up as a bit or period mismatch. It issues a second write and a fresh read edge in the middle of a frame; a design that restarted or re-latched would show a count of rising edges other than 64 or altered data. It rewrites an already-set read bit, which a level-triggered design would wrongly turn into a frame. It aborts a frame halfway, which catches designs that leave MDC high, keep busy set, or clobber the divider.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int FLD_W     = 5;
  localparam int DATA_W    = 16;
  localparam int BUS_W     = 32;
  localparam int BUS_AW    = 3;

  typedef enum logic [BUS_AW-1:0] {
    RA_CFG   = 3'd0,
    RA_CMD   = 3'd1,
    RA_ADDR  = 3'd2,
    RA_WDATA = 3'd3,
    RA_RDATA = 3'd4,
    RA_IND   = 3'd5
  } reg_addr_e;

  function automatic logic [FRAME_LEN-1:0] mdio_frame(
    input logic              rd,
    input logic [FLD_W-1:0]  phy,
    input logic [FLD_W-1:0]  rg,
    input logic [DATA_W-1:0] d
  );
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : d)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // half-period strobe: one tick every div+1 cycles while running
  assign tick = run && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_master_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic [DIV_W-1:0]     div,
  input  logic                 mdi,
  output logic                 mdc,
  output logic                 mdo,
  output logic                 mdoe,
  output logic                 busy,
  output logic                 done_rd,
  output logic [DATA_W-1:0]    rd_data
);
  logic                 active, is_rd, mdc_q, tick, last;
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] sh;
  logic [DATA_W-1:0]    cap;

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .div(div), .tick(tick)
  );

  // last falling MDC edge of the frame
  assign last    = active && tick && mdc_q && (idx == IDX_W'(FRAME_LEN-1));
  assign done_rd = last && is_rd;
  assign busy    = active;
  assign mdc     = mdc_q;
  assign mdo     = sh[FRAME_LEN-1];
  assign mdoe    = active && !(is_rd && (idx >= IDX_W'(TA_IDX)));
  assign rd_data = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_rd  <= 1'b0;
      mdc_q  <= 1'b0;
      idx    <= '0;
      sh     <= '0;
      cap    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      mdc_q  <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        is_rd  <= start_rd;
        sh     <= frame_in;
        idx    <= '0;
        mdc_q  <= 1'b0;
      end
    end else if (tick) begin
      mdc_q <= ~mdc_q;
      if (!mdc_q) begin
        // rising edge: sample the PHY during the data phase
        if (is_rd && (idx >= IDX_W'(DATA_IDX))) cap <= {cap[DATA_W-2:0], mdi};
      end else if (last) begin
        active <= 1'b0;
      end else begin
        // falling edge: present the next bit
        idx <= idx + 1'b1;
        sh  <= {sh[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  assert_mdo_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(mdo)) |-> $fell(mdc_q));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (idx >= $past(idx)));

  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mdc_q && !mdoe));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int              DIV_W    = 8,
  parameter logic [DIV_W-1:0] DIV_INIT = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              cmd_rd_q, nv_q, busy, done_rd;
  logic [FLD_W-1:0]  phy_q, rg_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, cap;
  logic              wr_cfg, wr_cmd, wr_ctl, abort, go_wr, go_rd;

  assign wr_cfg = bus_we && (bus_addr == RA_CFG);
  assign wr_cmd = bus_we && (bus_addr == RA_CMD);
  assign wr_ctl = bus_we && (bus_addr == RA_WDATA);
  assign abort  = wr_cfg && bus_wdata[BUS_W-1];
  assign go_wr  = wr_ctl && !busy && !abort;
  assign go_rd  = wr_cmd && bus_wdata[0] && !cmd_rd_q && !busy && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_INIT;
      cmd_rd_q <= 1'b0;
      phy_q    <= '0;
      rg_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      nv_q     <= 1'b0;
    end else begin
      if (wr_cfg && !bus_wdata[BUS_W-1]) div_q <= bus_wdata[DIV_W-1:0];
      if (wr_cmd) cmd_rd_q <= bus_wdata[0];
      if (bus_we && (bus_addr == RA_ADDR)) begin
        phy_q <= bus_wdata[8 +: FLD_W];
        rg_q  <= bus_wdata[0 +: FLD_W];
      end
      if (go_wr) wdata_q <= bus_wdata[DATA_W-1:0];
      if (abort) nv_q <= 1'b0;
      else if (go_rd) nv_q <= 1'b1;
      else if (done_rd) begin
        nv_q    <= 1'b0;
        rdata_q <= cap;
      end
    end
  end

  mdio_frame_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .start(go_wr || go_rd), .start_rd(go_rd),
    .frame_in(mdio_frame(go_rd, phy_q, rg_q, bus_wdata[DATA_W-1:0])),
    .div(div_q), .mdi(mdio_i),
    .mdc(mdc), .mdo(mdio_o), .mdoe(mdio_oe),
    .busy(busy), .done_rd(done_rd), .rd_data(cap)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CFG:   bus_rdata[DIV_W-1:0]  = div_q;
      RA_CMD:   bus_rdata[0]          = cmd_rd_q;
      RA_ADDR:  bus_rdata             = {19'd0, phy_q, 3'd0, rg_q};
      RA_WDATA: bus_rdata[DATA_W-1:0] = wdata_q;
      RA_RDATA: bus_rdata[DATA_W-1:0] = rdata_q;
      RA_IND:   bus_rdata[1:0]        = {nv_q, busy};
      default:  bus_rdata             = '0;
    endcase
  end

  assert_nv_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_q |-> busy);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !nv_q && !mdc));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, mdio_i = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe;

  int vec = 0, bad = 0, cyc = 0, rises = 0, last_rise = -1, per_bad = 0, exp_per = 2;
  logic [63:0] ob, oeb;
  logic [15:0] rdv = '0;

  always #10 clk = ~clk;
  always @(negedge clk) cyc++;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // simple PHY responder
  always @(posedge mdc) begin
    if (rises < 64) begin ob[63-rises] = mdio_o; oeb[63-rises] = mdio_oe; end
    if (last_rise >= 0 && (cyc - last_rise) != exp_per) per_bad++;
    last_rise = cyc;
    rises++;
  end
  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = rdv[63-rises];
    else mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic arm(input int div);
    rises = 0; last_rise = -1; per_bad = 0; exp_per = 2*(div+1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); rd(3'd5, v);
      if (v[1:0] == 2'b00) return;
    end
    check("R4 busy stuck", 1, 0);
  endtask

  function automatic logic [63:0] frm(input logic r, input logic [4:0] p,
                                      input logic [4:0] g, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 2'b10, d};
  endfunction

  task automatic frame(input logic r, input logic [4:0] p, input logic [4:0] g,
                       input logic [15:0] d, input int div);
    logic [31:0] v;
    arm(div);
    wr(3'd2, {19'd0, p, 3'd0, g});
    if (r) begin rdv = d; wr(3'd1, 0); wr(3'd1, 1); end
    else wr(3'd3, {16'd0, d});
    rd(3'd5, v);
    check(r ? "R5 nv+busy at read start" : "R4 busy at write start", v[1:0], r ? 2'b11 : 2'b01);
    wait_idle();
    check("R4 rises during busy", rises, 64);
    check("R7 mdc period", per_bad, 0);
    check("R10 idle pins", {mdc, mdio_oe}, 2'b00);
    if (r) begin
      check("R6 read header bits", ob[63:18], frm(1, p, g, 0) >> 18);
      check("R6 read oe pattern", oeb, {46'h3FFF_FFFF_FFFF, 18'h0});
      rd(3'd4, v);
      check("R5 read data", v, {16'd0, d});
    end else begin
      check("R2 write bits", ob, frm(0, p, g, d));
      check("R2 write oe", oeb, 64'hFFFF_FFFF_FFFF_FFFF);
    end
  endtask

  initial begin
    #1_000_000;
    check("watchdog", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, v); check("R10 reset indicator", v, 0);
    check("R10 reset pins", {mdc, mdio_oe}, 2'b00);
    rd(3'd0, v); check("R9 reset divider", v, 4);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R1 address layout", v, 32'h1F1F);

    for (int d = 0; d < 4; d++) begin
      wr(3'd0, d); rd(3'd0, v); check("R9 divider load", v, d);
      frame(0, 5'(d*7+3), 5'(d*5+1), 16'(16'hC35A ^ (d*16'h1111)), d);
      frame(1, 5'(d*3+2), 5'(31-d), 16'(16'h9E37 + d*16'h0F0F), d);
    end

    wr(3'd0, 0);
    for (int p = 0; p < 32; p++)
      frame(0, 5'(p), 5'(31-p), 16'(p*16'h0841 ^ 16'hA5C3), 0);

    // R3: read bit already 1, rewriting 1 starts nothing
    arm(0);
    wr(3'd1, 1); repeat (40) @(negedge clk);
    rd(3'd5, v); check("R3 no level-triggered read", {v[1:0], rises[7:0]}, 0);

    // R8: requests while busy ignored
    wr(3'd0, 1); wr(3'd1, 0); arm(1);
    wr(3'd2, {19'd0, 5'd9, 3'd0, 5'd17}); wr(3'd3, 32'h0000_1234);
    repeat (20) @(negedge clk);
    wr(3'd3, 32'h0000_BEEF); wr(3'd1, 1);
    wait_idle();
    check("R8 frame unchanged", ob, frm(0, 5'd9, 5'd17, 16'h1234));
    check("R8 single frame", rises, 64);
    rd(3'd3, v); check("R8 wdata kept", v, 32'h1234);
    repeat (50) @(negedge clk);
    check("R8 no late frame", rises, 64);

    // R9: abort mid-frame
    wr(3'd1, 0); arm(1);
    wr(3'd3, 32'h0000_5555); repeat (30) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    rd(3'd5, v); check("R9 abort indicator", v, 0);
    check("R9 abort pins", {mdc, mdio_oe}, 2'b00);
    rd(3'd0, v); check("R9 divider kept", v, 1);
    wr(3'd0, 2); rd(3'd0, v); check("R9 divider after abort", v, 2);
    frame(1, 5'd21, 5'd6, 16'h7A0C, 2);
    frame(0, 5'd4, 5'd30, 16'h0F0F, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule